// File: doc/BRIEF.md
# Byte-Permuting Protection Unit with OR-Merged Bank Base

This block sits on the cartridge side of a CPU byte bus. It answers a 2 MB window from 0x600000 to 0x7FFFFF. The lower half of that window holds two small registers. One is an 8-bit operand and the other is a 2-bit transform selector. A read anywhere in the window returns the operand after one of four fixed bit rearrangements. The selector picks which one. The upper half of the window takes writes that set a bank base of `d << 15`, which means 32 KB steps.

The bank base is merged into addresses in the first megabyte with a bitwise OR, not with an adder. Address bits that the base already sets are not carried into. A bank write is refused when the resulting base plus 64 KB would reach or pass the ROM size given on an input pin. The translated ROM address is produced combinationally from the CPU address. Read data is also combinational.

Top module: `prot_xform_bank`

## Requirements
- R1: A write in 0x600000–0x6FFFFF with address bit 1 equal to 1 loads the selector from data bits [1:0]. Data bits [7:2] are ignored. Selector encoding: 0 = shift left, 1 = shift right, 2 = nibble swap, 3 = bit reversal.
- R2: A write in 0x600000–0x6FFFFF with address bit 1 equal to 0 loads the 8-bit operand from data bits [7:0].
- R3: With selector 0, a read returns the operand shifted left by one. The result is truncated to 8 bits: the old bit 7 is lost and bit 0 is 0.
- R4: With selector 1, a read returns the operand shifted right by one, with 0 in bit 7.
- R5: With selector 2, a read returns the operand with bits [7:4] and [3:0] exchanged.
- R6: With selector 3, a read returns the operand with its bit order reversed, so bit i goes to bit 7−i.
- R7: Reads return data at every address in 0x600000–0x7FFFFF. Reads outside the window, writes, and idle cycles return 0x00. Reads change no state.
- R8: A write in 0x700000–0x7FFFFF sets the bank base to `d << 15` when `(d << 15) + 0x10000` is below the ROM size input.
- R9: A bank write whose `(d << 15) + 0x10000` is at or above the ROM size is refused, and the previous base stays.
- R10: For CPU addresses below 0x100000, the ROM address equals the CPU address ORed with the bank base. At and above 0x100000, the CPU address passes through unchanged.
- R11: Reset clears the operand, the selector and the bank base. The first read after reset returns 0x00, and low addresses translate to themselves.
- R12: Writes outside 0x600000–0x7FFFFF change neither the registers nor the bank base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Byte access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | CPU byte address |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data; 0x00 unless a read hits the window |
| rom_bytes | input | 25 | Size of the ROM in bytes |
| rom_addr | output | 24 | Translated ROM address |

## Verification
The assertions check several rules on every cycle:
- the selector holds unless a selector write occurs;
- an operand write lands one cycle later;
- at most one register is written per access;
- read data is zero outside window reads;
- the two pure permutations keep the population count;
- a low address keeps all its own bits in the translated address;
- an accepted bank write lands and a refused one leaves the base unchanged.

The exact bit patterns of each transform, the truncation in the shift cases, the precise OR results, the exact acceptance boundary against the ROM size, and the reset values can only be shown by the bench's chosen data and address scenarios.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [1:0] {
        XF_SHL   = 2'd0,
        XF_SHR   = 2'd1,
        XF_NSWAP = 2'd2,
        XF_REV   = 2'd3
    } xf_cmd_e;

    localparam int unsigned OPND_W = 8;

    typedef struct packed {
        logic [OPND_W-1:0] opnd;
        xf_cmd_e           sel;
    } xf_regs_t;

endpackage

// File: rtl/prot_decode.sv
module prot_decode #(
    parameter int unsigned          ADDR_W   = 24,
    parameter int unsigned          WIN_LOG2 = 21,
    parameter logic [ADDR_W-1:0]    WIN_BASE = 24'h600000,
    parameter int unsigned          LOW_LOG2 = 20
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              rd_hit,
    output logic              sel_wr,
    output logic              opnd_wr,
    output logic              bank_wr,
    output logic              low_win
);
    localparam int unsigned HALF_BIT = WIN_LOG2 - 1;

    logic in_win;
    logic wr_win;

    always_comb begin
        in_win  = (bus_addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
        wr_win  = bus_sel && bus_we && in_win;
        rd_hit  = bus_sel && !bus_we && in_win;
        sel_wr  = wr_win && !bus_addr[HALF_BIT] && bus_addr[1];
        opnd_wr = wr_win && !bus_addr[HALF_BIT] && !bus_addr[1];
        bank_wr = wr_win && bus_addr[HALF_BIT];
        low_win = (bus_addr[ADDR_W-1:LOW_LOG2] == '0);
    end

endmodule

// File: rtl/prot_xform.sv
module prot_xform
    import prot_pkg::*;
#(
    parameter int unsigned W = OPND_W
) (
    input  logic [W-1:0] din,
    input  xf_cmd_e      sel,
    output logic [W-1:0] dout
);
    localparam int unsigned HALF = W / 2;

    logic [W-1:0] rev;

    generate
        for (genvar i = 0; i < W; i++) begin : g_rev
            assign rev[i] = din[W-1-i];
        end
    endgenerate

    always_comb begin
        unique case (sel)
            XF_SHL:   dout = {din[W-2:0], 1'b0};
            XF_SHR:   dout = {1'b0, din[W-1:1]};
            XF_NSWAP: dout = {din[HALF-1:0], din[W-1:HALF]};
            XF_REV:   dout = rev;
            default:  dout = '0;
        endcase
    end

endmodule

// File: rtl/prot_bank.sv
module prot_bank #(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned BANK_SHIFT = 15,
    parameter int unsigned GUARD_LOG2 = 16,
    parameter int unsigned D_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_wr,
    input  logic [D_W-1:0]    wdata,
    input  logic [ADDR_W:0]   rom_bytes,
    output logic [ADDR_W-1:0] base_q
);
    localparam int unsigned EXT_W = ADDR_W + 2;
    localparam logic [EXT_W-1:0] GUARD = EXT_W'(1) << GUARD_LOG2;

    logic [EXT_W-1:0]  cand;
    logic [EXT_W-1:0]  need;
    logic              fits;
    logic [ADDR_W-1:0] base_d;

    always_comb begin
        cand   = {{(EXT_W-D_W){1'b0}}, wdata} << BANK_SHIFT;
        need   = cand + GUARD;
        fits   = need < {1'b0, rom_bytes};
        base_d = base_q;
        if (bank_wr && fits) begin
            base_d = cand[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

    // R8
    bank_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr && ((({{(EXT_W-D_W){1'b0}}, wdata} << BANK_SHIFT) + GUARD) < {1'b0, rom_bytes})
        |=> base_q == ADDR_W'($past(wdata)) << BANK_SHIFT)
        else $error("bank_take_chk");

    // R9
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank_wr && ((({{(EXT_W-D_W){1'b0}}, wdata} << BANK_SHIFT) + GUARD) < {1'b0, rom_bytes}))
        |=> $stable(base_q))
        else $error("bank_hold_chk");

endmodule

// File: rtl/prot_xform_bank.sv
module prot_xform_bank
    import prot_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 24,
    parameter int unsigned       WIN_LOG2   = 21,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 24'h600000,
    parameter int unsigned       LOW_LOG2   = 20,
    parameter int unsigned       BANK_SHIFT = 15,
    parameter int unsigned       GUARD_LOG2 = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [ADDR_W:0]   rom_bytes,
    output logic [ADDR_W-1:0] rom_addr
);
    logic rd_hit;
    logic sel_wr;
    logic opnd_wr;
    logic bank_wr;
    logic low_win;

    xf_regs_t          regs_d;
    xf_regs_t          regs_q;
    logic [7:0]        xf_out;
    logic [ADDR_W-1:0] base_q;

    prot_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_LOG2 (WIN_LOG2),
        .WIN_BASE (WIN_BASE),
        .LOW_LOG2 (LOW_LOG2)
    ) u_decode (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .rd_hit   (rd_hit),
        .sel_wr   (sel_wr),
        .opnd_wr  (opnd_wr),
        .bank_wr  (bank_wr),
        .low_win  (low_win)
    );

    prot_xform #(
        .W (OPND_W)
    ) u_xform (
        .din  (regs_q.opnd),
        .sel  (regs_q.sel),
        .dout (xf_out)
    );

    prot_bank #(
        .ADDR_W     (ADDR_W),
        .BANK_SHIFT (BANK_SHIFT),
        .GUARD_LOG2 (GUARD_LOG2),
        .D_W        (OPND_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_wr   (bank_wr),
        .wdata     (bus_wdata),
        .rom_bytes (rom_bytes),
        .base_q    (base_q)
    );

    always_comb begin
        regs_d = regs_q;
        if (sel_wr) begin
            regs_d.sel = xf_cmd_e'(bus_wdata[1:0]);
        end
        if (opnd_wr) begin
            regs_d.opnd = bus_wdata;
        end
        bus_rdata = rd_hit ? xf_out : 8'h00;
        rom_addr  = low_win ? (bus_addr | base_q) : bus_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{opnd: '0, sel: XF_SHL};
        end else begin
            regs_q <= regs_d;
        end
    end

    // R1
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(regs_q.sel))
        else $error("sel_hold_chk");

    // R2
    opnd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_wr |=> regs_q.opnd == $past(bus_wdata))
        else $error("opnd_load_chk");

    // R12
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_wr, opnd_wr, bank_wr}))
        else $error("one_target_chk");

    // R7
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> bus_rdata == 8'h00)
        else $error("rd_quiet_chk");

    // R5, R6
    perm_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && regs_q.sel[1] |-> $countones(bus_rdata) == $countones(regs_q.opnd))
        else $error("perm_pop_chk");

    // R10
    low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_win |-> (rom_addr & bus_addr) == bus_addr)
        else $error("low_keep_chk");

endmodule

// File: tb/prot_xform_bank_tb.sv
module prot_xform_bank_tb_top;
    localparam int PERIOD = 10;
    localparam int NV = 33;
    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_A = 2'd2;

    // {op[61:60], req[59:56], addr[55:32], data[31:24], expect[23:0]}
    localparam logic [61:0] VEC [NV] = '{
        {OP_W, 4'd2,  24'h600000, 8'hB4, 24'h000000},  // R2
        {OP_R, 4'd3,  24'h7FFFFE, 8'h00, 24'h000068},  // R3
        {OP_W, 4'd1,  24'h600002, 8'hFD, 24'h000000},  // R1
        {OP_R, 4'd4,  24'h612345, 8'h00, 24'h00005A},  // R4
        {OP_W, 4'd1,  24'h6FFFFF, 8'h02, 24'h000000},  // R1
        {OP_R, 4'd5,  24'h600000, 8'h00, 24'h00004B},  // R5
        {OP_W, 4'd1,  24'h600003, 8'h07, 24'h000000},  // R1
        {OP_R, 4'd6,  24'h7ABCDE, 8'h00, 24'h00002D},  // R6
        {OP_W, 4'd2,  24'h600004, 8'h01, 24'h000000},  // R2
        {OP_R, 4'd6,  24'h700001, 8'h00, 24'h000080},  // R6
        {OP_W, 4'd1,  24'h600002, 8'h00, 24'h000000},  // R1
        {OP_R, 4'd3,  24'h600000, 8'h00, 24'h000002},  // R3
        {OP_W, 4'd2,  24'h600000, 8'h80, 24'h000000},  // R2
        {OP_R, 4'd3,  24'h600000, 8'h00, 24'h000000},  // R3
        {OP_W, 4'd1,  24'h60000E, 8'h01, 24'h000000},  // R1
        {OP_R, 4'd4,  24'h600000, 8'h00, 24'h000040},  // R4
        {OP_W, 4'd12, 24'h800000, 8'h55, 24'h000000},  // R12
        {OP_W, 4'd12, 24'h5FFFFE, 8'h03, 24'h000000},  // R12
        {OP_R, 4'd12, 24'h600000, 8'h00, 24'h000040},  // R12
        {OP_R, 4'd7,  24'h800000, 8'h00, 24'h000000},  // R7
        {OP_R, 4'd7,  24'h5FFFFF, 8'h00, 24'h000000},  // R7
        {OP_W, 4'd8,  24'h700000, 8'h05, 24'h000000},  // R8
        {OP_A, 4'd10, 24'h001234, 8'h00, 24'h029234},  // R10
        {OP_A, 4'd10, 24'h0FFFFF, 8'h00, 24'h0FFFFF},  // R10
        {OP_A, 4'd10, 24'h040000, 8'h00, 24'h068000},  // R10
        {OP_A, 4'd10, 24'h200000, 8'h00, 24'h200000},  // R10
        {OP_W, 4'd8,  24'h7FFFFF, 8'h7D, 24'h000000},  // R8
        {OP_A, 4'd8,  24'h000000, 8'h00, 24'h3E8000},  // R8
        {OP_W, 4'd9,  24'h700000, 8'h7E, 24'h000000},  // R9
        {OP_A, 4'd9,  24'h000100, 8'h00, 24'h3E8100},  // R9
        {OP_W, 4'd9,  24'h700000, 8'hFF, 24'h000000},  // R9
        {OP_A, 4'd9,  24'h012345, 8'h00, 24'h3FA345},  // R9
        {OP_R, 4'd8,  24'h600000, 8'h00, 24'h000040}   // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [24:0] rom_bytes = 25'h0400000;
    logic [23:0] rom_addr;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    prot_xform_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rom_bytes (rom_bytes),
        .rom_addr  (rom_addr)
    );

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [23:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2;
        check(req, {16'h0, bus_rdata}, {16'h0, exp});
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic do_xlate(input string req, input logic [23:0] a, input logic [23:0] exp);
        @(negedge clk);
        bus_sel = 1'b0; bus_addr = a;
        #2;
        check(req, rom_addr, exp);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        do_read("R11", 24'h600000, 8'h00);
        do_xlate("R11", 24'h012345, 24'h012345);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", int'(VEC[i][59:56]));
            case (VEC[i][61:60])
                OP_W:    do_write(VEC[i][55:32], VEC[i][31:24]);
                OP_R:    do_read(tag, VEC[i][55:32], VEC[i][7:0]);
                default: do_xlate(tag, VEC[i][55:32], VEC[i][23:0]);
            endcase
        end

        // R7: read data quiet during a write in the window
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 24'h600002; bus_wdata = 8'h01;
        #2;
        check("R7", {16'h0, bus_rdata}, 24'h0);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;

        // R11: reset mid-run clears operand, selector and base
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_read("R11", 24'h600000, 8'h00);
        do_xlate("R11", 24'h012345, 24'h012345);

        // R8 / R9: acceptance boundary against a small ROM
        rom_bytes = 25'h0020000;
        do_write(24'h700000, 8'h01);
        do_xlate("R8", 24'h000010, 24'h008010);
        do_write(24'h700000, 8'h02);
        do_xlate("R9", 24'h000010, 24'h008010);

        finish_run();
    end

endmodule